// File: doc/BRIEF.md
# Split-Precision Pixel Convolution Combiner

This block runs a short convolution over pixels wider than eight bits by using two identical 8-bit lanes. Each incoming pixel is first widened from its effective precision (8 to 16 bits) to a full 16-bit word. Unused upper bits are sign-filled for signed data and cleared for unsigned data. The low byte then feeds one lane and the high byte feeds the other. Both lanes keep their own window of the most recent valid samples and multiply it by the same set of signed 8-bit coefficients.

The low lane's sum leaves through a fixed four-stage output path. The high lane's sum goes through a four-stage matching delay so that the two sums line up. The high sum is then shifted left by eight places, when shifting is enabled, and added to the low sum to give a 30-bit total. A field-select stage takes a 16-bit window from that total for a later gain stage and saturates the window when the discarded upper bits do not fit. A valid flag travels through every stage. The widened input pixel is delayed by the same total latency and comes out beside the result.

Top module: `split_conv_combiner`

## Requirements
- R1: During and directly after reset, outValid, sumOut, fieldOut and pixDly are all zero.
- R2: pixBits gives the effective pixel width. Values below 8 act as 8 and values above 16 act as 16. Bits at or above that width are replaced by copies of the top effective bit when pixSigned is 1, and by zeros when it is 0.
- R3: The low lane takes widened bits 7:0 as an unsigned value. The high lane takes bits 15:8, which are signed only when pixSigned is 1. Coefficient k sits at coefs bits 8k+7:8k as a signed two's-complement byte and weights the k-th most recent valid pixel (k=0 is the newest) in both lanes. The windows are zero after reset, and cycles with inValid low do not enter them.
- R4: With shiftEn=1, sumOut is the signed 30-bit value sum over k of coef_k*(hi_k*256 + lo_k).
- R5: With shiftEn=0, sumOut is sum over k of coef_k*(hi_k + lo_k).
- R6: The result for a pixel presented with inValid high before clock edge n appears with outValid high after edge n+6 (seven registers). outValid rises exactly once per valid pixel. sumOut and fieldOut hold their last result while outValid is low.
- R7: pixDly carries the widened pixel with the same latency as its result, so it is aligned with outValid.
- R8: fieldOut is sumOut arithmetically shifted right by 2*fieldSel (fieldSel 0 to 7). It saturates to 32767 or -32768 when the shifted value falls outside the signed 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Pixel on pixIn is valid this cycle |
| pixIn | input | 16 | Raw pixel word |
| pixBits | input | 5 | Effective pixel width, 8 to 16 |
| pixSigned | input | 1 | Pixel is two's complement |
| coefs | input | 32 | Four signed 8-bit coefficients, coefficient k at bits 8k+7:8k |
| shiftEn | input | 1 | Shift the high-lane sum left by 8 before adding |
| fieldSel | input | 3 | Output window offset in steps of two bits |
| outValid | output | 1 | Result on sumOut/fieldOut is new this cycle |
| sumOut | output | 30 | Full combined sum, signed |
| fieldOut | output | 16 | Selected, saturated 16-bit field, signed |
| pixDly | output | 16 | Widened pixel delayed to match the result |

## Verification
The assertions assume that shiftEn and fieldSel do not change while a valid pixel is still on its way to the output stage, and that the coefficients are equally steady. Under that assumption a lane whose window is all zero must produce a zero sum, unsigned widening must leave no bit set above the effective width, and the sign of the selected field must always match the sign of the full sum. The stimulus only changes configuration or coefficients after an idle flush longer than the pipeline. It runs bursts that mix valid and invalid cycles, drives junk bits above the effective width, and uses coefficient and pixel extremes that push the field select into both saturation limits.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int BYTE_W = 8;
  localparam int PIX_W  = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // a valid pixel enters the lane windows
    logic emit;     // a valid result enters the output registers
  } ctlStrobe_t;
endpackage

// File: rtl/scc_lane.sv
module scc_lane
  import scc_pkg::*;
#(
  parameter int TAPS      = 4,
  parameter int MATCH_DLY = 4,
  parameter int LANE_W    = 19
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture,
  input  logic signed [BYTE_W:0]   sample,
  input  logic [TAPS*BYTE_W-1:0]   coefs,
  output logic signed [LANE_W-1:0] laneSum
);
  localparam int PROD_W = 2 * BYTE_W + 1;

  logic signed [BYTE_W:0]   taps [TAPS];
  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [LANE_W-1:0] accNext;
  logic signed [LANE_W-1:0] sumReg;
  logic signed [LANE_W-1:0] dly [MATCH_DLY];
  logic                     tapsZero;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) taps[k] <= '0;
    end else if (capture) begin
      taps[0] <= sample;
      for (int k = 1; k < TAPS; k++) taps[k] <= taps[k-1];
    end
  end

  always_comb begin
    accNext  = '0;
    tapsZero = 1'b1;
    for (int k = 0; k < TAPS; k++) begin
      prod[k]  = taps[k] * $signed(coefs[BYTE_W*k +: BYTE_W]);
      accNext  = accNext + LANE_W'(prod[k]);
      tapsZero = tapsZero & (taps[k] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg <= '0;
      for (int d = 0; d < MATCH_DLY; d++) dly[d] <= '0;
    end else begin
      sumReg <= accNext;
      dly[0] <= sumReg;
      for (int d = 1; d < MATCH_DLY; d++) dly[d] <= dly[d-1];
    end
  end

  assign laneSum = dly[MATCH_DLY-1];

  AST_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tapsZero && !capture) |=> (sumReg == '0)); // R3
endmodule

// File: rtl/scc_control.sv
module scc_control
  import scc_pkg::*;
#(
  parameter int MATCH_DLY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       shiftEn,
  input  logic [2:0] fieldSel,
  output ctlStrobe_t strb,
  output logic       outValid
);
  localparam int LAT = MATCH_DLY + 3;

  logic [LAT-1:0] vPipe;
  logic           inFlight;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[LAT-2:0], inValid};
  end

  assign inFlight     = |vPipe[LAT-2:0];
  assign strb.capture = inValid;
  assign strb.emit    = vPipe[LAT-2];
  assign outValid     = vPipe[LAT-1];

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    inFlight |-> ($stable(fieldSel) && $stable(shiftEn))); // R8
endmodule

// File: rtl/scc_datapath.sv
module scc_datapath
  import scc_pkg::*;
#(
  parameter int TAPS       = 4,
  parameter int MATCH_DLY  = 4,
  parameter int SUM_W      = 30,
  parameter int OUT_W      = 16,
  parameter int FIELD_STEP = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctlStrobe_t              strb,
  input  logic [PIX_W-1:0]        pixIn,
  input  logic [4:0]              pixBits,
  input  logic                    pixSigned,
  input  logic [TAPS*BYTE_W-1:0]  coefs,
  input  logic                    shiftEn,
  input  logic [2:0]              fieldSel,
  output logic signed [SUM_W-1:0] sumOut,
  output logic signed [OUT_W-1:0] fieldOut,
  output logic [PIX_W-1:0]        pixDly
);
  localparam int LAT    = MATCH_DLY + 3;
  localparam int LANE_W = 2 * BYTE_W + 1 + $clog2(TAPS);

  logic [4:0]              effBits;
  logic [3:0]              topIdx;
  logic [PIX_W-1:0]        ext;
  logic signed [BYTE_W:0]  laneSample [2];
  logic signed [LANE_W-1:0] laneOut   [2];
  logic signed [SUM_W-1:0] hiExt, loExt, combSum, shifted;
  logic                    fits;
  logic [OUT_W-1:0]        satVal;
  logic [PIX_W-1:0]        pd [LAT];

  // width widening
  always_comb begin
    if (pixBits < 5'd8)       effBits = 5'd8;
    else if (pixBits > 5'd16) effBits = 5'd16;
    else                      effBits = pixBits;
    topIdx = 4'(effBits - 5'd1);
    for (int i = 0; i < PIX_W; i++) begin
      if (5'(i) < effBits) ext[i] = pixIn[i];
      else                 ext[i] = pixSigned & pixIn[topIdx];
    end
  end

  assign laneSample[0] = {1'b0, ext[BYTE_W-1:0]};
  assign laneSample[1] = {pixSigned & ext[PIX_W-1], ext[PIX_W-1:BYTE_W]};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    scc_lane #(.TAPS(TAPS), .MATCH_DLY(MATCH_DLY), .LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .capture (strb.capture),
      .sample  (laneSample[g]),
      .coefs   (coefs),
      .laneSum (laneOut[g])
    );
  end

  // combine and field select
  always_comb begin
    hiExt   = SUM_W'(laneOut[1]);
    loExt   = SUM_W'(laneOut[0]);
    combSum = shiftEn ? (hiExt <<< BYTE_W) + loExt : hiExt + loExt;
    shifted = combSum >>> (FIELD_STEP * fieldSel);
    fits    = (shifted[SUM_W-1:OUT_W-1] == '0) || (shifted[SUM_W-1:OUT_W-1] == '1);
    satVal  = shifted[SUM_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumOut   <= '0;
      fieldOut <= '0;
    end else if (strb.emit) begin
      sumOut   <= combSum;
      fieldOut <= fits ? shifted[OUT_W-1:0] : satVal;
    end
  end

  // pixel delay matched to result latency
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < LAT; s++) pd[s] <= '0;
    end else begin
      pd[0] <= ext;
      for (int s = 1; s < LAT; s++) pd[s] <= pd[s-1];
    end
  end

  assign pixDly = pd[LAT-1];

  AST_EXT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pixSigned |-> ((ext >> effBits) == '0)); // R2

  AST_FIELD_SIGN: assert property (@(posedge clk) disable iff (rst)
    (sumOut[SUM_W-1] == fieldOut[OUT_W-1])); // R8
endmodule

// File: rtl/split_conv_combiner.sv
module split_conv_combiner
  import scc_pkg::*;
#(
  parameter int TAPS       = 4,
  parameter int MATCH_DLY  = 4,
  parameter int SUM_W      = 30,
  parameter int OUT_W      = 16,
  parameter int FIELD_STEP = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [PIX_W-1:0]        pixIn,
  input  logic [4:0]              pixBits,
  input  logic                    pixSigned,
  input  logic [TAPS*BYTE_W-1:0]  coefs,
  input  logic                    shiftEn,
  input  logic [2:0]              fieldSel,
  output logic                    outValid,
  output logic signed [SUM_W-1:0] sumOut,
  output logic signed [OUT_W-1:0] fieldOut,
  output logic [PIX_W-1:0]        pixDly
);
  ctlStrobe_t strb;

  scc_control #(.MATCH_DLY(MATCH_DLY)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .shiftEn  (shiftEn),
    .fieldSel (fieldSel),
    .strb     (strb),
    .outValid (outValid)
  );

  scc_datapath #(
    .TAPS(TAPS), .MATCH_DLY(MATCH_DLY), .SUM_W(SUM_W),
    .OUT_W(OUT_W), .FIELD_STEP(FIELD_STEP)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .pixIn     (pixIn),
    .pixBits   (pixBits),
    .pixSigned (pixSigned),
    .coefs     (coefs),
    .shiftEn   (shiftEn),
    .fieldSel  (fieldSel),
    .sumOut    (sumOut),
    .fieldOut  (fieldOut),
    .pixDly    (pixDly)
  );
endmodule

// File: tb/split_conv_combiner_bench.sv
module split_conv_combiner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 4;
  localparam int LAT  = 7;
  localparam int QN   = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] pixIn = '0;
  logic [4:0]  pixBits = 5'd16;
  logic        pixSigned = 1'b0;
  logic [31:0] coefs = '0;
  logic        shiftEn = 1'b1;
  logic [2:0]  fieldSel = '0;
  logic        outValid;
  logic signed [29:0] sumOut;
  logic signed [15:0] fieldOut;
  logic [15:0] pixDly;

  split_conv_combiner u_split_conv_combiner (
    .clk(clk), .rst(rst), .inValid(inValid), .pixIn(pixIn), .pixBits(pixBits),
    .pixSigned(pixSigned), .coefs(coefs), .shiftEn(shiftEn), .fieldSel(fieldSel),
    .outValid(outValid), .sumOut(sumOut), .fieldOut(fieldOut), .pixDly(pixDly)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int wr = 0;
  int rd = 0;
  longint      expSum   [QN];
  int          expField [QN];
  logic [15:0] expPix   [QN];
  logic [15:0] hist     [TAPS];
  bit          histSgn  [TAPS];
  int          coefM    [TAPS];

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] widen(logic [15:0] raw, int bits, bit sgn);
    int eb;
    logic [15:0] r;
    eb = (bits < 8) ? 8 : ((bits > 16) ? 16 : bits);
    for (int i = 0; i < 16; i++) r[i] = (i < eb) ? raw[i] : (sgn & raw[eb-1]);
    return r;
  endfunction

  function automatic longint modelSum(bit sh);
    longint s = 0;
    for (int k = 0; k < TAPS; k++) begin
      longint lo, hi;
      lo = longint'(hist[k][7:0]);
      hi = histSgn[k] ? longint'($signed(hist[k][15:8])) : longint'(hist[k][15:8]);
      s += longint'(coefM[k]) * (sh ? hi * 256 + lo : hi + lo);
    end
    return s;
  endfunction

  function automatic int modelField(longint s, int sel);
    longint v = s >>> (2 * sel);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // output checker: compares each valid result against the model queue
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (rd >= wr) begin
        check("R6 unexpected outValid", 1, 0);
      end else begin
        check(shiftEn ? "R4 sum" : "R5 sum", longint'(sumOut), expSum[rd]);
        check("R8 field", longint'(fieldOut), longint'(expField[rd]));
        check("R7 pixDly", longint'(pixDly), longint'(expPix[rd]));
        rd++;
      end
    end
  end

  task automatic setCoefs(int c0, int c1, int c2, int c3);
    @(negedge clk);
    coefM[0] = c0; coefM[1] = c1; coefM[2] = c2; coefM[3] = c3;
    coefs = {8'(c3), 8'(c2), 8'(c1), 8'(c0)};
  endtask

  task automatic setCfg(int bits, bit sgn, bit sh, int sel);
    @(negedge clk);
    pixBits = 5'(bits); pixSigned = sgn; shiftEn = sh; fieldSel = 3'(sel);
  endtask

  task automatic sendPix(logic [15:0] raw, bit v);
    @(negedge clk);
    inValid = v;
    pixIn = raw;
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) begin
        hist[k] = hist[k-1];
        histSgn[k] = histSgn[k-1];
      end
      hist[0] = widen(raw, int'(pixBits), pixSigned);
      histSgn[0] = pixSigned;
      expSum[wr] = modelSum(shiftEn);
      expField[wr] = modelField(expSum[wr], int'(fieldSel));
      expPix[wr] = hist[0];
      wr++;
    end
  endtask

  task automatic flush();
    for (int i = 0; i < LAT + 3; i++) sendPix(16'hA5C3 ^ 16'(i * 4097), 1'b0);
    check("R6 result count", longint'(rd), longint'(wr));
  endtask

  task automatic tReset();
    check("R1 outValid", longint'(outValid), 0);
    check("R1 sumOut", longint'(sumOut), 0);
    check("R1 fieldOut", longint'(fieldOut), 0);
    check("R1 pixDly", longint'(pixDly), 0);
  endtask

  task automatic tUnsigned16();
    setCfg(16, 1'b0, 1'b1, 4);
    setCoefs(3, -2, 5, 1);
    sendPix(16'h0000, 1); sendPix(16'h00FF, 1); sendPix(16'hFF00, 1);
    sendPix(16'h1234, 1); sendPix(16'hFFFF, 1); sendPix(16'h8001, 1);
    flush();
  endtask

  task automatic tSigned12();
    setCfg(12, 1'b1, 1'b1, 2);
    setCoefs(-4, 7, 2, -1);
    sendPix(16'h0800, 1); sendPix(16'hA7FF, 1); sendPix(16'h3FFF, 1);
    sendPix(16'h5123, 1); sendPix(16'hF800, 1);
    flush();
    check("R2 signed widen", longint'(widen(16'h0800, 12, 1'b1)), longint'(16'hF800));
  endtask

  task automatic tUnsigned10();
    setCfg(10, 1'b0, 1'b1, 1);
    sendPix(16'hFFFF, 1); sendPix(16'hFC00, 1); sendPix(16'h8201, 1);
    flush();
  endtask

  task automatic tClamp();
    setCfg(4, 1'b1, 1'b1, 3);  // acts as 8 bits (R2)
    sendPix(16'h1280, 1); sendPix(16'h347F, 1);
    flush();
    setCfg(20, 1'b0, 1'b1, 3); // acts as 16 bits (R2)
    sendPix(16'h8000, 1); sendPix(16'hC3C3, 1);
    flush();
  endtask

  task automatic tNoShift();
    setCfg(16, 1'b1, 1'b0, 0);
    setCoefs(-7, 4, 9, -1);
    sendPix(16'h80FF, 1); sendPix(16'h7F01, 1); sendPix(16'hFF80, 1); sendPix(16'h1234, 1);
    flush();
  endtask

  task automatic tGaps();
    int first = -1;
    setCfg(16, 1'b1, 1'b1, 5);
    setCoefs(1, 2, 3, 4);
    sendPix(16'h0101, 1); sendPix(16'hDEAD, 0); sendPix(16'h0202, 1);
    sendPix(16'hBEEF, 0); sendPix(16'hBEEF, 0); sendPix(16'h0303, 1);
    sendPix(16'h0404, 1); sendPix(16'hFFFF, 0); sendPix(16'hF00D, 1);
    flush();
    // R6 latency: seven edges from capture to outValid
    sendPix(16'h0A0B, 1);
    for (int i = 1; i <= 20; i++) begin
      sendPix(16'h5555, 0);
      if (outValid && first < 0) first = i;
    end
    check("R6 latency edges", longint'(first), longint'(LAT));
    // R6 hold: outputs keep the last result while idle
    check("R6 hold sumOut", longint'(sumOut), expSum[wr-1]);
    check("R6 hold fieldOut", longint'(fieldOut), longint'(expField[wr-1]));
    check("R6 idle outValid", longint'(outValid), 0);
  endtask

  task automatic tField();
    setCfg(16, 1'b0, 1'b1, 0);
    setCoefs(127, 127, 127, 127);
    for (int i = 0; i < 4; i++) sendPix(16'hFFFF, 1);
    flush();
    check("R8 positive saturation", longint'(fieldOut), 32767);
    setCoefs(-128, -128, -128, -128);
    sendPix(16'hFFFF, 1);
    flush();
    check("R8 negative saturation", longint'(fieldOut), -32768);
    setCfg(16, 1'b0, 1'b1, 7);
    sendPix(16'hFFFF, 1);
    flush();
    check("R8 top window", longint'(fieldOut), -2048);
    setCfg(16, 1'b0, 1'b1, 3);
    setCoefs(1, 0, 0, 0);
    sendPix(16'h0123, 1);
    flush();
  endtask

  initial begin
    for (int k = 0; k < TAPS; k++) begin
      hist[k] = '0; histSgn[k] = 1'b0; coefM[k] = 0;
    end
    repeat (3) @(negedge clk);
    tReset();
    rst = 1'b0;
    @(negedge clk);
    tReset();
    tUnsigned16();
    tSigned12();
    tUnsigned10();
    tClamp();
    tNoShift();
    tGaps();
    tField();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule